// File: doc/BRIEF.md
# I2C Controller Event Status and Interrupt Vector

This unit holds the sticky event flags of an I2C master controller. The bus engine reports events as one-cycle pulses: lost arbitration, missing acknowledge, access complete, receive data ready, transmit data ready, receive overrun and transmit underflow. A level input reports whether the bus is busy. Software sees the flags through a 16-bit register port. It masks the five interrupt-capable events with an enable register and clears flags by writing ones.

A single interrupt line is raised while any enabled flag is pending. A vector register gives software a short code for the most urgent enabled event. Reading that register also retires the event it reported, so an interrupt handler can work through events with one read per event.

Top module: `i2c_evt_irq_unit`

## Requirements
- R1: After reset the enable register, every status flag, the vector and `irq` are all zero.
- R2: The enable register sits at offset 0x04. Bits 4..0 are writable, with bit 0 for lost arbitration, bit 1 for no acknowledge, bit 2 for access ready, bit 3 for receive ready and bit 4 for transmit ready. All other bits read as zero.
- R3: An event pulse sets its status flag from the next cycle on, and the flag stays set until it is cleared. The status register at offset 0x08 places the flags as follows: bit 0 lost arbitration, bit 1 no acknowledge, bit 2 access ready, bit 3 receive ready, bit 4 transmit ready, bit 10 transmit underflow, bit 11 receive overrun.
- R4: A write to the status register clears each flag whose bit is written as one. Flags whose bit is written as zero keep their value.
- R5: Status bit 12 always shows the live `bus_busy` input. Writes to bit 12 have no effect, and bus busy never raises `irq`. Bits 5..9 and 13..15 read as zero.
- R6: `irq` is high exactly while at least one of status bits 4..0 is set together with its enable bit.
- R7: The vector register at offset 0x0C reads 0 when no enabled flag is pending. Otherwise it gives the code of the pending enabled event with the lowest code: 1 lost arbitration, 2 no acknowledge, 3 access ready, 4 receive ready, 5 transmit ready. Disabled flags are never reported.
- R8: A read of the vector register clears the flag it reported and no other flag. A read that returns 0 clears nothing.
- R9: When an event pulse arrives in the same cycle as a clear of the same flag, whether by a status write or by a vector read, the flag remains set.
- R10: Receive overrun and transmit underflow set their status bits but never drive `irq` or the vector.
- R11: Reads of any other offset return zero. Writes to the vector register or to any other offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a vector read has a side effect) |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from `reg_addr` |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_nack | input | 1 | Pulse: no acknowledge |
| ev_acc_rdy | input | 1 | Pulse: access ready |
| ev_rx_rdy | input | 1 | Pulse: receive data ready |
| ev_tx_rdy | input | 1 | Pulse: transmit data ready |
| ev_rx_ovr | input | 1 | Pulse: receive overrun |
| ev_tx_udf | input | 1 | Pulse: transmit underflow |
| bus_busy | input | 1 | Level: bus busy |
| irq | output | 1 | Interrupt request |

## Verification
Two kinds of same-cycle collision are checked. In the first, an event pulse meets a write-one-to-clear of the same flag. In the second, it meets a vector read that retires that flag. The bench drives the event input in the same cycle as the status write or the vector read. It then reads the status and vector registers again to confirm that the flag survived. A separate check repeats the clear and the vector read without the pulse, which shows that each clear path works on its own.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

    localparam int NUM_IRQ  = 5;   // interrupt-capable events
    localparam int NUM_FLAG = 7;   // all sticky event flags
    localparam int VEC_W    = $clog2(NUM_IRQ + 1);
    localparam int BUSY_POS = 12;

    localparam int OFS_EN   = 'h04;
    localparam int OFS_STAT = 'h08;
    localparam int OFS_VEC  = 'h0C;

    // Bit i of this struct is flag index i; lower index = more urgent.
    typedef struct packed {
        logic rx_ovr;
        logic tx_udf;
        logic tx_rdy;
        logic rx_rdy;
        logic acc_rdy;
        logic nack;
        logic arb_lost;
    } evt_t;

    typedef enum logic [VEC_W-1:0] {
        VEC_NONE = 3'd0,
        VEC_ARB  = 3'd1,
        VEC_NACK = 3'd2,
        VEC_ACC  = 3'd3,
        VEC_RX   = 3'd4,
        VEC_TX   = 3'd5
    } vec_code_e;

    // Position of flag index in the status word.
    function automatic int flag_pos(input int idx);
        case (idx)
            5:       return 10;
            6:       return 11;
            default: return idx;
        endcase
    endfunction

endpackage

// File: rtl/i2c_evt_flag.sv
module i2c_evt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Set has priority over clear.
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/i2c_evt_vec.sv
module i2c_evt_vec #(
    parameter int NUM_IRQ = 5,
    parameter int VEC_W   = 3
) (
    input  logic [NUM_IRQ-1:0] pend_i,
    output logic [VEC_W-1:0]   code_o,
    output logic [NUM_IRQ-1:0] hit_o
);
    // Scan from the least urgent to the most urgent so the lowest index wins.
    always_comb begin
        code_o = '0;
        hit_o  = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                code_o   = VEC_W'(i + 1);
                hit_o    = '0;
                hit_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_evt_irq_unit.sv
module i2c_evt_irq_unit
    import i2c_evt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_arb_lost,
    input  logic              ev_nack,
    input  logic              ev_acc_rdy,
    input  logic              ev_rx_rdy,
    input  logic              ev_tx_rdy,
    input  logic              ev_rx_ovr,
    input  logic              ev_tx_udf,
    input  logic              bus_busy,
    output logic              irq
);
    logic sel_en, sel_stat, sel_vec;
    logic wr_en, wr_stat, vec_take;

    assign sel_en   = (reg_addr == ADDR_W'(OFS_EN));
    assign sel_stat = (reg_addr == ADDR_W'(OFS_STAT));
    assign sel_vec  = (reg_addr == ADDR_W'(OFS_VEC));
    assign wr_en    = reg_wr & sel_en;
    assign wr_stat  = reg_wr & sel_stat;
    assign vec_take = reg_rd & sel_vec;

    evt_t                evt;
    logic [NUM_FLAG-1:0] evt_bits;
    logic [NUM_FLAG-1:0] flag_q;
    logic [NUM_IRQ-1:0]  en_q;
    logic [NUM_IRQ-1:0]  pend;
    logic [NUM_IRQ-1:0]  vec_hit;
    logic [VEC_W-1:0]    vec_code;
    logic [DATA_W-1:0]   stat_word;

    always_comb begin
        evt.arb_lost = ev_arb_lost;
        evt.nack     = ev_nack;
        evt.acc_rdy  = ev_acc_rdy;
        evt.rx_rdy   = ev_rx_rdy;
        evt.tx_rdy   = ev_tx_rdy;
        evt.tx_udf   = ev_tx_udf;
        evt.rx_ovr   = ev_rx_ovr;
    end
    assign evt_bits = evt;

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (wr_en) en_q <= reg_wdata[NUM_IRQ-1:0];
    end

    for (genvar g = 0; g < NUM_FLAG; g++) begin : g_flag
        localparam int POS = flag_pos(g);
        logic clr;
        if (g < NUM_IRQ) begin : g_irq
            assign clr = (wr_stat & reg_wdata[POS]) | (vec_take & vec_hit[g]);
        end else begin : g_plain
            assign clr = wr_stat & reg_wdata[POS];
        end
        i2c_evt_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (evt_bits[g]),
            .clr_i  (clr),
            .flag_o (flag_q[g])
        );
    end

    assign pend = flag_q[NUM_IRQ-1:0] & en_q;
    assign irq  = |pend;

    i2c_evt_vec #(
        .NUM_IRQ (NUM_IRQ),
        .VEC_W   (VEC_W)
    ) u_vec (
        .pend_i (pend),
        .code_o (vec_code),
        .hit_o  (vec_hit)
    );

    always_comb begin
        stat_word = '0;
        for (int i = 0; i < NUM_FLAG; i++) begin
            stat_word[flag_pos(i)] = flag_q[i];
        end
        stat_word[BUSY_POS] = bus_busy;
    end

    always_comb begin
        if (sel_en)        reg_rdata = {{(DATA_W-NUM_IRQ){1'b0}}, en_q};
        else if (sel_stat) reg_rdata = stat_word;
        else if (sel_vec)  reg_rdata = {{(DATA_W-VEC_W){1'b0}}, vec_code};
        else               reg_rdata = '0;
    end
endmodule

// File: rtl/i2c_evt_irq_chk.sv
module i2c_evt_irq_chk
    import i2c_evt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                reg_wr,
    input logic                reg_rd,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic                ev_arb_lost,
    input logic                bus_busy,
    input logic                irq,
    input logic [NUM_FLAG-1:0] flag_q
);
    // R3
    a_r3_event_sets: assert property (@(posedge clk) disable iff (rst)
        ev_arb_lost |=> flag_q[0]);

    // R4
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(OFS_STAT) && reg_wdata[0] && !ev_arb_lost)
        |=> !flag_q[0]);

    // R5
    a_r5_busy_mirror: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_W'(OFS_STAT)) |-> (reg_rdata[BUSY_POS] == bus_busy));

    // R7
    a_r7_vec_agrees_irq: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_W'(OFS_VEC)) |-> ((reg_rdata != '0) == irq));

    // R8
    a_r8_read_retires: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == ADDR_W'(OFS_VEC) && reg_rdata == DATA_W'(1) && !ev_arb_lost)
        |=> !flag_q[0]);

    // R9
    a_r9_event_wins: assert property (@(posedge clk) disable iff (rst)
        (ev_arb_lost && reg_wr && reg_addr == ADDR_W'(OFS_STAT) && reg_wdata[0])
        |=> flag_q[0]);
endmodule

bind i2c_evt_irq_unit i2c_evt_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .ev_arb_lost (ev_arb_lost),
    .bus_busy    (bus_busy),
    .irq         (irq),
    .flag_q      (flag_q)
);

// File: tb/test_i2c_evt_irq_unit.sv
`timescale 1ns/1ps
module test_i2c_evt_irq_unit;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam logic [7:0] A_EN = 8'h04, A_STAT = 8'h08, A_VEC = 8'h0C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [6:0] ev = '0;  // {ovr, udf, tx, rx, acc, nack, arb}
    logic bus_busy = 1'b0;
    logic irq;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    i2c_evt_irq_unit i_i2c_evt_irq_unit (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_arb_lost(ev[0]), .ev_nack(ev[1]), .ev_acc_rdy(ev[2]),
        .ev_rx_rdy(ev[3]), .ev_tx_rdy(ev[4]), .ev_tx_udf(ev[5]),
        .ev_rx_ovr(ev[6]), .bus_busy(bus_busy), .irq(irq)
    );

    typedef struct packed {
        logic [6:0]  ev;
        logic [4:0]  en;
        logic [15:0] stat;
        logic [2:0]  vec;
        logic        irq;
    } row_t;

    localparam int NROW = 8;
    localparam row_t TABLE [NROW] = '{
        '{7'h01, 5'h1F, 16'h0001, 3'd1, 1'b1},
        '{7'h10, 5'h1F, 16'h0010, 3'd5, 1'b1},
        '{7'h1C, 5'h1F, 16'h001C, 3'd3, 1'b1},
        '{7'h1C, 5'h18, 16'h001C, 3'd4, 1'b1},
        '{7'h03, 5'h00, 16'h0003, 3'd0, 1'b0},
        '{7'h60, 5'h1F, 16'h0C00, 3'd0, 1'b0},
        '{7'h7F, 5'h10, 16'h0C1F, 3'd5, 1'b1},
        '{7'h06, 5'h04, 16'h0006, 3'd3, 1'b1}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One register cycle: inputs set after a falling edge, read data sampled
    // before the rising edge that commits any side effect.
    task automatic cyc(input logic wr, input logic rd, input logic [7:0] a,
                       input logic [15:0] wd, input logic [6:0] e,
                       output logic [15:0] rdv);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd; ev = e;
        #1 rdv = reg_rdata;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 8'h00; reg_wdata = '0; ev = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        logic [15:0] junk;
        cyc(1'b1, 1'b0, a, d, 7'h00, junk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        cyc(1'b0, 1'b1, a, 16'h0, 7'h00, d);
    endtask

    task automatic pulse(input logic [6:0] e);
        logic [15:0] junk;
        cyc(1'b0, 1'b0, 8'h00, 16'h0, e, junk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_EN, d);   check("R1 enable", d, 16'h0);
        rd(A_STAT, d); check("R1 status", d, 16'h0);
        rd(A_VEC, d);  check("R1 vector", d, 16'h0);
        check("R1 irq", {15'h0, irq}, 16'h0);

        // Table walk: R3, R6, R7, R10
        for (int i = 0; i < NROW; i++) begin
            wr(A_STAT, 16'hFFFF);
            wr(A_EN, {11'h0, TABLE[i].en});
            pulse(TABLE[i].ev);
            check("R6 irq", {15'h0, irq}, {15'h0, TABLE[i].irq});
            rd(A_STAT, d); check("R3 status", d, TABLE[i].stat);
            rd(A_VEC, d);  check("R7 vector", d, {13'h0, TABLE[i].vec});
        end

        // R2 enable width
        wr(A_STAT, 16'hFFFF);
        wr(A_EN, 16'hFFFF);
        rd(A_EN, d); check("R2 enable readback", d, 16'h001F);

        // R5 busy mirror, write ignored, no irq
        bus_busy = 1'b1;
        wr(A_STAT, 16'hF3E0);
        rd(A_STAT, d); check("R5 busy bit", d, 16'h1000);
        check("R5 busy no irq", {15'h0, irq}, 16'h0);
        bus_busy = 1'b0;
        rd(A_STAT, d); check("R5 busy low", d, 16'h0000);

        // R4 partial write-one-to-clear
        pulse(7'h1F);
        wr(A_STAT, 16'h0005);
        rd(A_STAT, d); check("R4 partial clear", d, 16'h001A);

        // R8 vector read retires one flag at a time
        wr(A_STAT, 16'hFFFF);
        pulse(7'h03);
        rd(A_VEC, d);  check("R8 first vector", d, 16'd1);
        rd(A_STAT, d); check("R8 after first read", d, 16'h0002);
        rd(A_VEC, d);  check("R8 second vector", d, 16'd2);
        rd(A_VEC, d);  check("R8 empty vector", d, 16'd0);
        check("R8 irq low", {15'h0, irq}, 16'h0);

        // R9 event beats status write
        pulse(7'h01);
        cyc(1'b1, 1'b0, A_STAT, 16'h0001, 7'h01, d);
        rd(A_STAT, d); check("R9 event vs write", d, 16'h0001);

        // R9 event beats vector read
        cyc(1'b0, 1'b1, A_VEC, 16'h0, 7'h01, d);
        check("R9 vector value", d, 16'd1);
        rd(A_VEC, d); check("R9 event vs vector read", d, 16'd1);

        // R11 other offsets
        pulse(7'h10);
        wr(8'h10, 16'hFFFF);
        rd(8'h10, d); check("R11 unmapped read", d, 16'h0);
        wr(A_VEC, 16'hFFFF);
        rd(A_STAT, d); check("R11 vector write ignored", d, 16'h0010);
        rd(A_EN, d);   check("R11 enable untouched", d, 16'h001F);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(A_STAT, d); check("R1 status after reset", d, 16'h0);
        rd(A_EN, d);   check("R1 enable after reset", d, 16'h0);
        check("R1 irq after reset", {15'h0, irq}, 16'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule